// File: doc/BRIEF.md
# Command Ring Fetch Engine

This block moves codec command words from host memory to the outbound link. Software keeps a circular buffer of 256 four-byte commands in memory. It writes a new command into the slot after the current write index and then moves the write index onto that slot, so the write index always names the newest valid entry. While fetching is switched on, the engine notices that its read index trails the write index. It steps the read index forward, reads the 32-bit word at the ring base plus four times that index through a simple request/grant/response memory port, and offers the word on a valid/ready command output.

A small register slave sets the engine up. It holds the write index, a read index that reports the last entry consumed, a control register with a fetch-enable bit and a read-only size register. A software-started clear brings the read index back to zero. The clear completes by itself once no fetch is in flight, and a busy flag shows that it is still pending. Each command word is also split into its fields (codec address, direct flag, node, verb and parameter) for the downstream serializer.

Top module: `cmd_ring_fetch`

## Requirements
- R1: After reset, the write-index, read-index and control registers read 0x0000, the size register reads 0x0042, and neither `cmd_valid` nor `mem_req` is asserted.
- R2: While control bit 1 (fetch enable) is 0, no new memory request starts and the read index does not change. A fetch already granted still completes.
- R3: Each fetch requests the address `ring_base + 4*((rd+1) mod 256)`, where rd is the read index at the time of the fetch.
- R4: The engine keeps fetching until the read index equals the write index. Words leave `cmd_word` in ring order, and the read index (register 1, bits 7:0) reads back the last entry fetched.
- R5: Both indices wrap from 255 to 0. The entry after index 255 is fetched from index 0.
- R6: At most one memory request is outstanding. `mem_req` and `mem_addr` stay stable until `mem_gnt`, and no request is raised while a response is awaited.
- R7: While `cmd_valid` is high and `cmd_ready` is low, `cmd_word` holds steady and no new fetch starts.
- R8: Writing register 1 with bit 15 set starts a clear of the read index. Bit 15 reads 1 until the clear completes, and the clear completes only when no fetch is in flight. A write to register 1 with bit 15 clear has no effect.
- R9: The decode outputs carry the fields of `cmd_word`: codec address in bits 31:28, direct flag in bit 27, node in bits 26:20, verb in bits 19:8 and parameter in bits 7:0.
- R10: Register 3 (size) always reads 0x0042 (bits 1:0 = 2 selects 256 entries, bits 7:4 = 4 says only that size is supported). Writes to it are ignored.
- R11: Register 0 (write index) stores bits 7:0 of the written data. Its upper bits read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 write index, 1 read index, 2 control, 3 size |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Combinational read data for `reg_addr` |
| ring_base | input | ADDR_W | Byte address of ring entry 0 |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | ADDR_W | Memory read byte address |
| mem_gnt | input | 1 | Request accepted |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| cmd_valid | output | 1 | Command word available |
| cmd_ready | input | 1 | Link accepts command |
| cmd_word | output | 32 | Command word |
| cmd_codec | output | 4 | Codec address field |
| cmd_direct | output | 1 | Direct flag |
| cmd_node | output | 7 | Node field |
| cmd_verb | output | 12 | Verb field |
| cmd_param | output | 8 | Parameter field |

## Verification
The embedded assertions check on every cycle the properties that hold locally. They cover the request staying stable until grant, the single outstanding fetch, the rule that no fetch starts while disabled or while the output is stalled, the output staying steady under back-pressure, the read index stepping by one per response, and the clear completing. Whether the whole stream comes out in ring order, across the wrap and after clears, can only be shown by the bench. It tracks its own expected index for each granted address and compares every delivered word and its decoded fields with a memory image it computes itself. The bench also covers the register behaviours: reset values, ignored writes and the clear-busy readback.

// File: rtl/cmdring_pkg.sv
package cmdring_pkg;

    localparam int CMD_W = 32;
    localparam int REG_W = 16;

    localparam logic [1:0] REG_WP   = 2'd0;
    localparam logic [1:0] REG_RP   = 2'd1;
    localparam logic [1:0] REG_CTRL = 2'd2;
    localparam logic [1:0] REG_SIZE = 2'd3;

    localparam int CTRL_RUN_BIT = 1;
    localparam int RP_CLR_BIT   = 15;

    // bits 1:0 = 2 -> 256 entries, bits 7:4 = 4 -> only that size offered
    localparam logic [REG_W-1:0] SIZE_VALUE = 16'h0042;

    typedef struct packed {
        logic [3:0]  codec;
        logic        direct;
        logic [6:0]  node;
        logic [11:0] verb;
        logic [7:0]  param;
    } cmd_fields_t;

    typedef enum logic [1:0] {
        FS_IDLE = 2'd0,
        FS_REQ  = 2'd1,
        FS_WAIT = 2'd2
    } fetch_state_e;

    function automatic cmd_fields_t split_cmd(input logic [CMD_W-1:0] w);
        return cmd_fields_t'(w);
    endfunction

endpackage

// File: rtl/cmdring_regs.sv
module cmdring_regs
    import cmdring_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [1:0]        reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic [IDX_W-1:0]  rd_ptr,
    input  logic              clr_done,
    output logic [IDX_W-1:0]  wr_ptr,
    output logic              fetch_en,
    output logic              clr_pending
);

    logic clr_set;
    logic wdata_unused;

    assign clr_set      = reg_we && (reg_addr == REG_RP) && reg_wdata[RP_CLR_BIT];
    assign wdata_unused = ^reg_wdata;

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr      <= '0;
            fetch_en    <= 1'b0;
            clr_pending <= 1'b0;
        end else begin
            if (reg_we && reg_addr == REG_WP)
                wr_ptr <= reg_wdata[IDX_W-1:0];
            if (reg_we && reg_addr == REG_CTRL)
                fetch_en <= reg_wdata[CTRL_RUN_BIT];
            if (clr_set)
                clr_pending <= 1'b1;
            else if (clr_done)
                clr_pending <= 1'b0;
        end
    end

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            REG_WP:   reg_rdata[IDX_W-1:0] = wr_ptr;
            REG_RP: begin
                reg_rdata[IDX_W-1:0]  = rd_ptr;
                reg_rdata[RP_CLR_BIT] = clr_pending;
            end
            REG_CTRL: reg_rdata[CTRL_RUN_BIT] = fetch_en;
            default:  reg_rdata = SIZE_VALUE;
        endcase
    end

    // R8: a clear request is visible as busy on the following cycle
    assert_clr_busy_R8: assert property (@(posedge clk) disable iff (rst)
        clr_set |=> clr_pending);

    // R8: completion drops the busy flag unless a new clear arrives
    assert_clr_release_R8: assert property (@(posedge clk) disable iff (rst)
        (clr_pending && clr_done && !clr_set) |=> !clr_pending);

endmodule

// File: rtl/cmdring_fetch.sv
module cmdring_fetch
    import cmdring_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fetch_en,
    input  logic [IDX_W-1:0]  wr_ptr,
    input  logic              clr_pending,
    output logic              clr_done,
    output logic [IDX_W-1:0]  rd_ptr,
    input  logic [ADDR_W-1:0] mem_base,
    input  logic              out_busy,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_gnt,
    input  logic              mem_rvalid,
    input  logic [CMD_W-1:0]  mem_rdata,
    output logic              load,
    output logic [CMD_W-1:0]  load_data
);

    localparam int BYTE_SHIFT = $clog2(CMD_W / 8);

    fetch_state_e state;
    logic [IDX_W-1:0] nxt_idx;
    logic             work;

    assign work     = fetch_en && (rd_ptr != wr_ptr) && !out_busy;
    assign clr_done = (state == FS_IDLE) && clr_pending;
    assign mem_req  = (state == FS_REQ);
    assign mem_addr = mem_base + (ADDR_W'(nxt_idx) << BYTE_SHIFT);
    assign load     = (state == FS_WAIT) && mem_rvalid;
    assign load_data = mem_rdata;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= FS_IDLE;
            rd_ptr  <= '0;
            nxt_idx <= '0;
        end else begin
            unique case (state)
                FS_IDLE: begin
                    if (clr_pending) begin
                        rd_ptr <= '0;
                    end else if (work) begin
                        nxt_idx <= rd_ptr + 1'b1;
                        state   <= FS_REQ;
                    end
                end
                FS_REQ: begin
                    if (mem_gnt)
                        state <= FS_WAIT;
                end
                FS_WAIT: begin
                    if (mem_rvalid) begin
                        rd_ptr <= nxt_idx;
                        state  <= FS_IDLE;
                    end
                end
                default: state <= FS_IDLE;
            endcase
        end
    end

    // R6: an ungranted request keeps its address
    assert_req_stable_R6: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr)));

    // R6: after a grant the request drops until the response has been taken
    assert_one_outstanding_R6: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_gnt) |=> !mem_req);

    // R2: a fresh request needs fetch enable in the cycle that launched it
    assert_no_fetch_off_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_req) |-> $past(fetch_en));

    // R7: a stalled output blocks new fetches
    assert_stall_blocks_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_req) |-> $past(!out_busy));

    // R4: each response moves the read index on by exactly one
    assert_step_one_R4: assert property (@(posedge clk) disable iff (rst)
        load |=> (rd_ptr == $past(rd_ptr) + 1'b1));

    // R8: a completed clear leaves the read index at zero
    assert_clear_zero_R8: assert property (@(posedge clk) disable iff (rst)
        clr_done |=> (rd_ptr == '0));

endmodule

// File: rtl/cmdring_outstage.sv
module cmdring_outstage
    import cmdring_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CMD_W-1:0] load_data,
    input  logic             cmd_ready,
    output logic             cmd_valid,
    output logic [CMD_W-1:0] cmd_word
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_valid <= 1'b0;
            cmd_word  <= '0;
        end else if (load) begin
            cmd_valid <= 1'b1;
            cmd_word  <= load_data;
        end else if (cmd_valid && cmd_ready) begin
            cmd_valid <= 1'b0;
        end
    end

    // R7: back-pressure holds the word in place
    assert_hold_word_R7: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_word)));

    // R7: a new word never lands on top of an unaccepted one
    assert_no_overwrite_R7: assert property (@(posedge clk) disable iff (rst)
        load |-> !cmd_valid);

endmodule

// File: rtl/cmd_ring_fetch.sv
module cmd_ring_fetch
    import cmdring_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [1:0]        reg_addr,
    input  logic [15:0]       reg_wdata,
    output logic [15:0]       reg_rdata,
    input  logic [ADDR_W-1:0] ring_base,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_gnt,
    input  logic              mem_rvalid,
    input  logic [31:0]       mem_rdata,
    output logic              cmd_valid,
    input  logic              cmd_ready,
    output logic [31:0]       cmd_word,
    output logic [3:0]        cmd_codec,
    output logic              cmd_direct,
    output logic [6:0]        cmd_node,
    output logic [11:0]       cmd_verb,
    output logic [7:0]        cmd_param
);

    logic [IDX_W-1:0] wr_ptr;
    logic [IDX_W-1:0] rd_ptr;
    logic             fetch_en;
    logic             clr_pending;
    logic             clr_done;
    logic             load;
    logic [CMD_W-1:0] load_data;
    cmd_fields_t      fields;

    cmdring_regs #(.IDX_W(IDX_W)) u_regs (
        .clk         (clk),
        .rst         (rst),
        .reg_we      (reg_we),
        .reg_addr    (reg_addr),
        .reg_wdata   (reg_wdata),
        .reg_rdata   (reg_rdata),
        .rd_ptr      (rd_ptr),
        .clr_done    (clr_done),
        .wr_ptr      (wr_ptr),
        .fetch_en    (fetch_en),
        .clr_pending (clr_pending)
    );

    cmdring_fetch #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_fetch (
        .clk         (clk),
        .rst         (rst),
        .fetch_en    (fetch_en),
        .wr_ptr      (wr_ptr),
        .clr_pending (clr_pending),
        .clr_done    (clr_done),
        .rd_ptr      (rd_ptr),
        .mem_base    (ring_base),
        .out_busy    (cmd_valid),
        .mem_req     (mem_req),
        .mem_addr    (mem_addr),
        .mem_gnt     (mem_gnt),
        .mem_rvalid  (mem_rvalid),
        .mem_rdata   (mem_rdata),
        .load        (load),
        .load_data   (load_data)
    );

    cmdring_outstage u_out (
        .clk       (clk),
        .rst       (rst),
        .load      (load),
        .load_data (load_data),
        .cmd_ready (cmd_ready),
        .cmd_valid (cmd_valid),
        .cmd_word  (cmd_word)
    );

    // R9: field split of the presented word
    assign fields     = split_cmd(cmd_word);
    assign cmd_codec  = fields.codec;
    assign cmd_direct = fields.direct;
    assign cmd_node   = fields.node;
    assign cmd_verb   = fields.verb;
    assign cmd_param  = fields.param;

endmodule

// File: tb/test_cmd_ring_fetch.sv
module test_cmd_ring_fetch;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [15:0] reg_wdata = 16'h0;
    logic [15:0] reg_rdata;
    logic [31:0] ring_base = 32'h0001_0000;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_gnt = 1'b0;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = 32'h0;
    logic        cmd_valid;
    logic        cmd_ready = 1'b0;
    logic [31:0] cmd_word;
    logic [3:0]  cmd_codec;
    logic        cmd_direct;
    logic [6:0]  cmd_node;
    logic [11:0] cmd_verb;
    logic [7:0]  cmd_param;

    always #10 clk = ~clk;

    cmd_ring_fetch i_cmd_ring_fetch (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ring_base(ring_base),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_gnt(mem_gnt),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .cmd_valid(cmd_valid),
        .cmd_ready(cmd_ready), .cmd_word(cmd_word), .cmd_codec(cmd_codec),
        .cmd_direct(cmd_direct), .cmd_node(cmd_node), .cmd_verb(cmd_verb),
        .cmd_param(cmd_param)
    );

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    // bench-side model state
    logic [7:0] exp_fetch_idx = 8'd0;
    int         idx_q[$];
    bit         busy = 1'b0;
    int         lat = 0;
    logic [31:0] gaddr = 32'h0;
    bit         prev_req = 1'b0;
    logic [31:0] prev_addr = 32'h0;
    bit         hold_prev = 1'b0;
    logic [31:0] held_word = 32'h0;
    int         last_idx = -1;
    bit         saw_wrap = 1'b0;
    int         delivered = 0;
    int         req_rise = 0;
    int         viol_stable = 0;
    int         viol_outst = 0;
    int         viol_stall = 0;
    int         ready_mode = 0;   // 0 random, 1 forced low

    function automatic logic [31:0] mem_word(input logic [31:0] a);
        return (a * 32'h9E37_79B1) ^ {a[15:0], a[31:16]} ^ 32'h1234_5678;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] a, output logic [15:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic drain(input logic [7:0] target);
        logic [15:0] d;
        for (int c = 0; c < 4000; c++) begin
            @(negedge clk);
            reg_read(2'd1, d);
            if (d[7:0] == target && !cmd_valid && !mem_req && !busy && !mem_gnt)
                return;
        end
    endtask

    // memory responder, consumer and protocol monitor, all on the falling edge
    always @(negedge clk) begin
        if (rst) begin
            mem_gnt = 1'b0; mem_rvalid = 1'b0; busy = 1'b0;
            prev_req = 1'b0; hold_prev = 1'b0; cmd_ready = 1'b0;
        end else begin
            // R6 stability of an ungranted request
            if (prev_req && !mem_gnt && (!mem_req || mem_addr != prev_addr))
                viol_stable++;
            // R7 no fetch launched while the output is occupied
            if (mem_req && !prev_req) begin
                req_rise++;
                if (cmd_valid) viol_stall++;
            end
            mem_rvalid = 1'b0;
            if (mem_gnt) begin
                mem_gnt = 1'b0;
                busy = 1'b1;
                lat = $urandom % 3;
                if (mem_req) viol_outst++;
            end else if (busy) begin
                if (mem_req) viol_outst++;
                if (lat == 0) begin
                    mem_rvalid = 1'b1;
                    mem_rdata = mem_word(gaddr);
                    busy = 1'b0;
                end else begin
                    lat--;
                end
            end else if (mem_req) begin
                if ($urandom % 3 != 0) begin
                    mem_gnt = 1'b1;
                    gaddr = mem_addr;
                    exp_fetch_idx = exp_fetch_idx + 8'd1;
                    check(mem_addr == ring_base + {22'b0, exp_fetch_idx, 2'b00},
                          "R3", "fetch address", mem_addr,
                          ring_base + {22'b0, exp_fetch_idx, 2'b00});
                    idx_q.push_back(int'(exp_fetch_idx));
                end
            end
            prev_req = mem_req && !mem_gnt;
            prev_addr = mem_addr;

            // consumer
            if (hold_prev && !(cmd_valid && cmd_word == held_word))
                viol_stall++;
            cmd_ready = (ready_mode == 0) ? ($urandom % 4 != 0) : 1'b0;
            if (cmd_valid && cmd_ready) begin
                if (idx_q.size() == 0) begin
                    check(1'b0, "R4", "unexpected word", cmd_word, 32'h0);
                end else begin
                    int ix;
                    logic [31:0] ew;
                    ix = idx_q.pop_front();
                    ew = mem_word(ring_base + {22'b0, 8'(ix), 2'b00});
                    check(cmd_word == ew, "R4", "word order", cmd_word, ew);
                    check({cmd_codec, cmd_direct, cmd_node, cmd_verb, cmd_param} == ew,
                          "R9", "field split",
                          {cmd_codec, cmd_direct, cmd_node, cmd_verb, cmd_param}, ew);
                    if (ix == 0 && last_idx == 255) saw_wrap = 1'b1;
                    last_idx = ix;
                    delivered++;
                end
            end
            hold_prev = cmd_valid && !cmd_ready;
            held_word = cmd_word;
        end
    end

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", total, bad);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL R4 watchdog: actual=timeout expected=completion");
            summary();
            $finish;
        end
    end

    initial begin
        logic [15:0] d;
        logic [7:0]  cur_wp;
        int          r0, rp_snap;
        void'($urandom(7));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        reg_read(2'd0, d); check(d == 16'h0, "R1", "write index", d, 16'h0);
        reg_read(2'd1, d); check(d == 16'h0, "R1", "read index", d, 16'h0);
        reg_read(2'd2, d); check(d == 16'h0, "R1", "control", d, 16'h0);
        reg_read(2'd3, d); check(d == 16'h0042, "R1", "size", d, 16'h0042);
        check(!cmd_valid && !mem_req, "R1", "idle outputs", {cmd_valid, mem_req}, 0);

        // R11 write-index width
        reg_write(2'd0, 16'hABCD);
        reg_read(2'd0, d); check(d == 16'h00CD, "R11", "write index bits", d, 16'h00CD);

        // R2 fetch disabled: nothing consumed
        reg_write(2'd0, 16'h0005);
        r0 = req_rise;
        repeat (30) @(negedge clk);
        check(req_rise == r0, "R2", "requests while off", req_rise, r0);
        reg_read(2'd1, d); check(d == 16'h0, "R2", "read index while off", d, 16'h0);
        check(!cmd_valid, "R2", "output while off", cmd_valid, 0);

        // R10 size register ignores writes
        reg_write(2'd3, 16'hFFFF);
        reg_read(2'd3, d); check(d == 16'h0042, "R10", "size after write", d, 16'h0042);
        reg_read(2'd2, d); check(d == 16'h0, "R10", "control untouched", d, 16'h0);

        // R4 first batch
        reg_write(2'd2, 16'h0002);
        reg_read(2'd2, d); check(d == 16'h0002, "R4", "enable readback", d, 16'h0002);
        drain(8'd5);
        reg_read(2'd1, d); check(d == 16'h0005, "R4", "read index after batch", d, 16'h0005);
        check(delivered == 5, "R4", "delivered count", delivered, 5);

        // random bursts, crossing the wrap point
        cur_wp = 8'd5;
        for (int k = 0; k < 25; k++) begin
            cur_wp = cur_wp + 8'(1 + $urandom % 30);
            reg_write(2'd0, {8'h0, cur_wp});
            drain(cur_wp);
            reg_read(2'd1, d);
            check(d == {8'h0, cur_wp}, "R4", "read index tracks write", d, {8'h0, cur_wp});
        end
        check(saw_wrap, "R5", "entry 0 after entry 255", saw_wrap, 1);

        // R7 back-pressure: one fetch only, word held
        ready_mode = 1;
        r0 = req_rise;
        cur_wp = cur_wp + 8'd3;
        reg_write(2'd0, {8'h0, cur_wp});
        repeat (40) @(negedge clk);
        check(cmd_valid, "R7", "word held while stalled", cmd_valid, 1);
        check(req_rise == r0 + 1, "R7", "fetches while stalled", req_rise, r0 + 1);
        ready_mode = 0;
        drain(cur_wp);

        // R2 disable in mid-stream
        cur_wp = cur_wp + 8'd40;
        reg_write(2'd0, {8'h0, cur_wp});
        repeat (12) @(negedge clk);
        reg_write(2'd2, 16'h0000);
        repeat (10) @(negedge clk);
        reg_read(2'd1, d); rp_snap = int'(d); r0 = req_rise;
        repeat (40) @(negedge clk);
        reg_read(2'd1, d);
        check(int'(d) == rp_snap, "R2", "read index frozen", d, rp_snap);
        check(req_rise == r0, "R2", "no request after disable", req_rise, r0);
        check(d[7:0] != cur_wp, "R2", "stopped before end", d, {8'h0, cur_wp});
        reg_write(2'd2, 16'h0002);
        drain(cur_wp);

        // R8 clear while idle
        reg_write(2'd2, 16'h0000);
        reg_write(2'd0, 16'h0000);
        reg_write(2'd1, 16'h8000);
        reg_read(2'd1, d); check(d[15], "R8", "busy flag after clear", d, 16'h8000);
        @(negedge clk);
        reg_read(2'd1, d); check(d == 16'h0, "R8", "clear done", d, 16'h0);
        exp_fetch_idx = 8'd0;
        reg_write(2'd0, 16'h0007);
        reg_write(2'd1, 16'h0033);
        reg_read(2'd1, d); check(d == 16'h0, "R8", "plain write ignored", d, 16'h0);
        reg_write(2'd2, 16'h0002);
        drain(8'd7);
        reg_read(2'd1, d); check(d == 16'h0007, "R8", "restart from zero", d, 16'h0007);

        // R8 clear with a fetch in flight
        reg_write(2'd0, 16'h003C);
        for (int c = 0; c < 100 && !mem_req; c++) @(negedge clk);
        reg_write(2'd1, 16'h8000);
        reg_read(2'd1, d); check(d[15], "R8", "busy while in flight", d, 16'h8000);
        for (int c = 0; c < 50; c++) begin
            reg_read(2'd1, d);
            if (!d[15]) break;
            @(negedge clk);
        end
        exp_fetch_idx = 8'd0;
        check(d == 16'h0, "R8", "cleared after in-flight fetch", d, 16'h0);
        drain(8'h3C);
        reg_read(2'd1, d); check(d == 16'h003C, "R8", "refill after clear", d, 16'h003C);

        // protocol totals
        check(viol_stable == 0, "R6", "unstable request", viol_stable, 0);
        check(viol_outst == 0, "R6", "second outstanding request", viol_outst, 0);
        check(viol_stall == 0, "R7", "stall rule breaks", viol_stall, 0);
        check(idx_q.size() == 0, "R4", "undelivered fetches", idx_q.size(), 0);

        finished = 1'b1;
        summary();
        $finish;
    end

endmodule